// File: doc/BRIEF.md
# Coalescing Write Buffer

This block holds pending write bursts in front of a memory device. Every queued entry keeps the start address and byte size of its write, plus a tag equal to that address aligned down to a burst boundary. An incoming write whose aligned tag is already held is folded into the existing entry and does not take a new slot. A write with a new tag is appended in arrival order. The scheduler takes entries from the head, oldest first, and popping an entry drops its tag.

A read-lookup port lets a read be answered from the buffer. The read's aligned address is first compared against all held tags at once. The lookup then reports a hit only if one entry's byte range fully covers the read's range. When a write is turned away because the buffer is full, the block later pulses a retry once a slot frees up. The requester keeps each request inside one burst.

Top module: `wq_coalesce`

## Requirements
- R1: After reset the buffer is empty: `occupancy` is 0, `deq_valid` is 0, `wr_ready` is 1, `merge_count` is 0, and `rd_resp_valid`, `rd_hit` and `wr_retry` are 0.
- R2: The tag of an address is that address with its low log2(BURST_BYTES) bits cleared, where BURST_BYTES is a power of two. With 16-byte bursts, 0x0410 and 0x041F share a tag and 0x0420 has a different one.
- R3: An accepted write whose tag matches a held entry adds no entry. Occupancy stays the same, `merge_count` rises by one, and the held entry's address and size do not change.
- R4: An accepted write whose tag matches no held entry is appended at the tail. Occupancy rises by one, and the number of entries always equals the number of held tags.
- R5: A lookup presented on `rd_valid` gets `rd_resp_valid` high one cycle later. `rd_hit` is 1 only if some entry satisfies entry_addr <= rd_addr and rd_addr + rd_size <= entry_addr + entry_size. A matching tag without full coverage is a miss.
- R6: A lookup whose tag matches no held entry reports `rd_hit` = 0.
- R7: `deq_addr` and `deq_size` show the oldest entry whenever `deq_valid` is 1. A `deq_req` removes that entry and its tag, so a later write to the same burst is appended, not merged.
- R8: When a pop and a write arrive in the same cycle, the popped entry's tag is removed before the write is compared. A write to the burst being popped is therefore appended.
- R9: With DEPTH entries held, `wr_ready` is 0 and an offered write changes neither the queue nor `merge_count`.
- R10: After a write has been refused, `wr_retry` pulses high for exactly one cycle. The pulse comes on the clock edge after the one at which occupancy first drops below DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request offered |
| wr_ready | output | 1 | Buffer can take a write this cycle |
| wr_addr | input | ADDR_W | Write start byte address |
| wr_size | input | SIZE_W | Write length in bytes |
| wr_retry | output | 1 | One-cycle pulse telling a refused requester to try again |
| rd_valid | input | 1 | Read lookup offered |
| rd_addr | input | ADDR_W | Read start byte address |
| rd_size | input | SIZE_W | Read length in bytes |
| rd_resp_valid | output | 1 | Lookup result is valid |
| rd_hit | output | 1 | Read fully covered by a queued write |
| deq_req | input | 1 | Scheduler pops the head entry |
| deq_valid | output | 1 | Head entry present |
| deq_addr | output | ADDR_W | Head entry start address |
| deq_size | output | SIZE_W | Head entry size |
| occupancy | output | OCC_W | Number of queued entries |
| merge_count | output | CNT_W | Number of writes folded into existing entries |

## Verification
A lost or stale tag shows up as a wrong merge decision on the very next write to that burst. Occupancy then either fails to rise or rises by one too many, and the error is visible one cycle after the write. Stale tags also make later lookups hit wrongly, and that appears on `rd_hit` one cycle after the lookup. A head pointer that drifts shows up directly on `deq_addr`, so the dequeue order checks catch it on the next pop. A fault in the same-cycle ordering is visible only when a pop and a write to the same burst coincide, so that case gets its own directed test.

// File: rtl/wq_pkg.sv
package wq_pkg;
  // width needed to index n slots (at least one bit)
  function automatic int unsigned idx_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wq_tag_cam.sv
module wq_tag_cam #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 16
) (
  input  logic [TAG_W-1:0]            key,
  input  logic [DEPTH-1:0]            vld,
  input  logic [DEPTH-1:0][TAG_W-1:0] tags,
  output logic [DEPTH-1:0]            match,
  output logic                        any
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = vld[i] && (tags[i] == key);
  end
  assign any = |match;
endmodule

// File: rtl/wq_span_check.sv
module wq_span_check #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 5
) (
  input  logic [DEPTH-1:0]             vld,
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  input  logic [DEPTH-1:0][SIZE_W-1:0] ent_size,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [SIZE_W-1:0]            rd_size,
  output logic                         covered
);
  localparam int EW = ADDR_W + 1;
  logic [DEPTH-1:0] cov;
  logic [EW-1:0]    rd_end;

  assign rd_end = {1'b0, rd_addr} + EW'(rd_size);

  for (genvar i = 0; i < DEPTH; i++) begin : g_span
    logic [EW-1:0] e_end;
    assign e_end  = {1'b0, ent_addr[i]} + EW'(ent_size[i]);
    assign cov[i] = vld[i] && (ent_addr[i] <= rd_addr) && (rd_end <= e_end);
  end
  assign covered = |cov;
endmodule

// File: rtl/wq_coalesce.sv
module wq_coalesce #(
  parameter int ADDR_W      = 16,
  parameter int DEPTH       = 4,
  parameter int BURST_BYTES = 16,
  parameter int CNT_W       = 16,
  parameter int SIZE_W      = $clog2(BURST_BYTES) + 1,
  parameter int OCC_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [SIZE_W-1:0] wr_size,
  output logic              wr_retry,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [SIZE_W-1:0] rd_size,
  output logic              rd_resp_valid,
  output logic              rd_hit,
  input  logic              deq_req,
  output logic              deq_valid,
  output logic [ADDR_W-1:0] deq_addr,
  output logic [SIZE_W-1:0] deq_size,
  output logic [OCC_W-1:0]  occupancy,
  output logic [CNT_W-1:0]  merge_count
);
  localparam int PTR_W = wq_pkg::idx_bits(DEPTH);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(BURST_BYTES - 1);
  localparam logic [OCC_W-1:0]  FULL_LVL = OCC_W'(DEPTH);

  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
  logic [DEPTH-1:0][ADDR_W-1:0] ent_tag;
  logic [DEPTH-1:0][SIZE_W-1:0] ent_size;
  logic [DEPTH-1:0]             ent_vld;
  logic [PTR_W-1:0]             head, tail;
  logic [OCC_W-1:0]             count;
  logic                         stall_pend;

  logic             full, pop, acc, push, merged;
  logic [DEPTH-1:0] pop_mask, wr_cmp_vld, wr_match, rd_match;
  logic             wr_tag_any, rd_tag_any, rd_cover;
  logic [ADDR_W-1:0] wr_tag, rd_tag;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full      = (count == FULL_LVL);
  assign wr_ready  = !full;
  assign deq_valid = (count != '0);
  assign deq_addr  = ent_addr[head];
  assign deq_size  = ent_size[head];
  assign occupancy = count;

  assign pop      = deq_req && deq_valid;
  assign pop_mask = pop ? (DEPTH'(1) << head) : '0;
  // the popped tag is out of the set before the write is compared
  assign wr_cmp_vld = ent_vld & ~pop_mask;

  assign wr_tag = wr_addr & ~LOW_MASK;
  assign rd_tag = rd_addr & ~LOW_MASK;

  wq_tag_cam #(.DEPTH(DEPTH), .TAG_W(ADDR_W)) wr_cam_i (
    .key(wr_tag), .vld(wr_cmp_vld), .tags(ent_tag),
    .match(wr_match), .any(wr_tag_any)
  );

  wq_tag_cam #(.DEPTH(DEPTH), .TAG_W(ADDR_W)) rd_cam_i (
    .key(rd_tag), .vld(ent_vld), .tags(ent_tag),
    .match(rd_match), .any(rd_tag_any)
  );

  wq_span_check #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) span_i (
    .vld(ent_vld), .ent_addr(ent_addr), .ent_size(ent_size),
    .rd_addr(rd_addr), .rd_size(rd_size), .covered(rd_cover)
  );

  assign acc    = wr_valid && wr_ready;
  assign merged = acc && wr_tag_any;
  assign push   = acc && !wr_tag_any;

  // payload registers: no reset, written only at the tail
  always_ff @(posedge clk) begin
    if (push) begin
      ent_addr[tail] <= wr_addr;
      ent_tag[tail]  <= wr_tag;
      ent_size[tail] <= wr_size;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
      head    <= '0;
      tail    <= '0;
      count   <= '0;
    end else begin
      if (pop) begin
        ent_vld[head] <= 1'b0;
        head          <= step(head);
      end
      if (push) begin
        ent_vld[tail] <= 1'b1;
        tail          <= step(tail);
      end
      case ({push, pop})
        2'b10:   count <= count + OCC_W'(1);
        2'b01:   count <= count - OCC_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      merge_count   <= '0;
      rd_resp_valid <= 1'b0;
      rd_hit        <= 1'b0;
      stall_pend    <= 1'b0;
      wr_retry      <= 1'b0;
    end else begin
      if (merged) merge_count <= merge_count + CNT_W'(1);
      rd_resp_valid <= rd_valid;
      rd_hit        <= rd_valid && rd_tag_any && rd_cover;
      wr_retry      <= stall_pend && !full;
      if (wr_valid && full)        stall_pend <= 1'b1;
      else if (stall_pend && !full) stall_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/wq_coalesce_chk.sv
module wq_coalesce_chk #(
  parameter int DEPTH = 4,
  parameter int OCC_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [OCC_W-1:0] count,
  input logic [DEPTH-1:0] vld,
  input logic             merged,
  input logic             push,
  input logic             pop,
  input logic             wr_retry,
  input logic             rd_hit
);
  AST_OCC_EQ_TAGS: assert property (@(posedge clk) disable iff (rst)
    32'(count) == $countones(vld));  // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    32'(count) <= DEPTH);  // R9
  AST_MERGE_NO_GROW: assert property (@(posedge clk) disable iff (rst)
    merged && !pop |=> count == $past(count));  // R3
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    pop && !push |=> count == $past(count) - OCC_W'(1));  // R7
  AST_RETRY_ROOM: assert property (@(posedge clk) disable iff (rst)
    wr_retry |-> 32'($past(count)) < DEPTH);  // R10
  AST_HIT_HAS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    rd_hit |-> $past(count) != '0);  // R5
endmodule

bind wq_coalesce wq_coalesce_chk #(.DEPTH(DEPTH), .OCC_W(OCC_W)) chk_i (
  .clk(clk), .rst(rst), .count(count), .vld(ent_vld), .merged(merged),
  .push(push), .pop(pop), .wr_retry(wr_retry), .rd_hit(rd_hit)
);

// File: tb/wq_coalesce_tb_top.sv
module wq_coalesce_tb_top;
  localparam int ADDR_W = 16, DEPTH = 4, BURST = 16, CNT_W = 16;
  localparam int SIZE_W = $clog2(BURST) + 1, OCC_W = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1;
  logic wr_valid = 0, rd_valid = 0, deq_req = 0;
  logic [ADDR_W-1:0] wr_addr = 0, rd_addr = 0;
  logic [SIZE_W-1:0] wr_size = 0, rd_size = 0;
  logic wr_ready, wr_retry, rd_resp_valid, rd_hit, deq_valid;
  logic [ADDR_W-1:0] deq_addr;
  logic [SIZE_W-1:0] deq_size;
  logic [OCC_W-1:0]  occupancy;
  logic [CNT_W-1:0]  merge_count;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  wq_coalesce #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BURST_BYTES(BURST), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_retry(wr_retry),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_size(rd_size),
    .rd_resp_valid(rd_resp_valid), .rd_hit(rd_hit), .deq_req(deq_req),
    .deq_valid(deq_valid), .deq_addr(deq_addr), .deq_size(deq_size),
    .occupancy(occupancy), .merge_count(merge_count)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one write; state sampled at the following falling edge
  task automatic do_write(input logic [15:0] a, input int sz);
    @(negedge clk); wr_valid = 1; wr_addr = a; wr_size = SIZE_W'(sz);
    @(negedge clk); wr_valid = 0;
  endtask
  task automatic do_read(input logic [15:0] a, input int sz);
    @(negedge clk); rd_valid = 1; rd_addr = a; rd_size = SIZE_W'(sz);
    @(negedge clk); rd_valid = 0;
  endtask
  task automatic do_deq();
    @(negedge clk); deq_req = 1;
    @(negedge clk); deq_req = 0;
  endtask

  // vector: op[43:42] 0=write 1=read 2=dequeue, req[41:38], addr[37:22], size[21:16], exp[15:0]
  // write exp = {merges, occupancy}; read exp = hit; dequeue exp = head address before the pop
  localparam int NV = 12;
  localparam logic [43:0] VEC [NV] = '{
    {2'd0, 4'd4,  16'h0100, 6'd16, 16'h0001},  // R4 new burst
    {2'd0, 4'd3,  16'h0104, 6'd4,  16'h0101},  // R3 merge into 0x0100
    {2'd0, 4'd4,  16'h0220, 6'd8,  16'h0102},  // R4
    {2'd1, 4'd5,  16'h0104, 6'd4,  16'h0001},  // R5 covered
    {2'd1, 4'd5,  16'h0228, 6'd4,  16'h0000},  // R5 tag match, not covered
    {2'd1, 4'd5,  16'h0222, 6'd4,  16'h0001},  // R5 covered
    {2'd1, 4'd6,  16'h0300, 6'd4,  16'h0000},  // R6 no tag
    {2'd2, 4'd7,  16'h0000, 6'd0,  16'h0100},  // R7 oldest first
    {2'd0, 4'd7,  16'h0108, 6'd4,  16'h0102},  // R7 tag gone, appended
    {2'd1, 4'd7,  16'h0104, 6'd4,  16'h0000},  // R7 old entry gone
    {2'd2, 4'd7,  16'h0000, 6'd0,  16'h0220},  // R7
    {2'd2, 4'd7,  16'h0000, 6'd0,  16'h0108}   // R7
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(occupancy == 0 && !deq_valid && wr_ready && merge_count == 0 &&
          !rd_resp_valid && !rd_hit && !wr_retry, "R1", int'(occupancy), 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [15:0] a, e; int sz; string rq;
      op = VEC[i][43:42]; a = VEC[i][37:22]; sz = int'(VEC[i][21:16]); e = VEC[i][15:0];
      rq = $sformatf("R%0d vec%0d", VEC[i][41:38], i);
      case (op)
        2'd0: begin
          do_write(a, sz);
          check({merge_count[7:0], 8'(occupancy)} == e, rq,
                int'({merge_count[7:0], 8'(occupancy)}), int'(e));
        end
        2'd1: begin
          do_read(a, sz);
          check(rd_resp_valid && rd_hit == e[0], rq, int'(rd_hit), int'(e[0]));
        end
        default: begin
          check(deq_valid && deq_addr == e, rq, int'(deq_addr), int'(e));
          do_deq();
        end
      endcase
    end
    check(occupancy == 0 && !deq_valid, "R7 drained", int'(occupancy), 0);

    // R2 alignment boundaries: 0x041F shares 0x0410's burst, 0x0420 does not
    do_write(16'h0410, 4);
    do_write(16'h041F, 1);
    check(occupancy == 1 && merge_count == 2, "R2 same burst", int'(occupancy), 1);
    check(deq_addr == 16'h0410 && deq_size == 4, "R3 entry unchanged", int'(deq_addr), 'h410);
    do_write(16'h0420, 1);
    check(occupancy == 2, "R2 next burst", int'(occupancy), 2);
    do_deq(); do_deq();

    // R8 pop and write to the same burst in one cycle
    do_write(16'h0500, 8);
    @(negedge clk); deq_req = 1; wr_valid = 1; wr_addr = 16'h0504; wr_size = 4;
    @(negedge clk); deq_req = 0; wr_valid = 0;
    check(occupancy == 1 && merge_count == 2, "R8 appended", int'(occupancy), 1);
    check(deq_addr == 16'h0504, "R8 head", int'(deq_addr), 'h504);
    do_deq();

    // R9 fill, then offer a write
    for (int k = 0; k < DEPTH; k++) do_write(16'h0600 + 16'(k * 16), 4);
    check(occupancy == DEPTH && !wr_ready, "R9 full", int'(wr_ready), 0);
    do_write(16'h0600, 4);  // would merge if accepted
    check(occupancy == DEPTH && merge_count == 2, "R9 refused", int'(merge_count), 2);
    check(!wr_retry, "R10 no early retry", int'(wr_retry), 0);
    // R10 retry after room appears
    do_deq();
    check(occupancy == DEPTH - 1 && !wr_retry, "R10 not yet", int'(wr_retry), 0);
    @(negedge clk);
    check(wr_retry, "R10 pulse", int'(wr_retry), 1);
    @(negedge clk);
    check(!wr_retry, "R10 single pulse", int'(wr_retry), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule